// File: doc/BRIEF.md
# Time Slot Interchange Switch

This block switches byte-wide TDM channels between slots. A frame holds `NUM_CH` slots and runs at one slot per clock. A pulse on `frameSync` marks slot 0. In each slot the byte on `inByte` is stored in a data memory. At the same time the connection entry for the output slot with the same number is looked up. The entry names the input channel whose byte from the previous frame goes out on that output slot. Instead of a channel, the entry can also force a constant byte that it holds itself.

The data memory has two banks. One bank fills with the current frame while the other replays the previous frame, and the two swap on every `frameSync`. This gives a fixed delay of one frame through the switch.

A host register port reads and writes the connection entries as 32-bit words at byte addresses, one entry every four bytes. Each entry has three parts:

- an input channel field;
- a substitute flag with the constant byte beside it;
- one spare bit that software may use freely and that the hardware ignores.

Top module: `tsi_switch`

## Requirements
- R1: The block takes one slot per clock. A clock with `frameSync` high is slot 0, and the following clocks count up through `NUM_CH`-1 and wrap to 0.
- R2: The result for the slot handled in clock t appears on the rising edge two clocks later, with `outValid` high and `outSlot` equal to that slot. With entry bit 16 clear, `outByte` is the byte that arrived in input slot entry[15:0] during the previous frame.
- R3: With entry bit 16 set, `outByte` equals entry bits [7:0], whatever the data memory holds.
- R4: Only the low log2(`NUM_CH`) bits of the channel field select the input. Higher bits of [15:0] have no effect.
- R5: Entry bit 17 is stored and read back as written, and it does not change `outByte`.
- R6: Bits [31:18] of every entry read as zero, and writes to them are dropped.
- R7: Entry N sits at byte address 4*N. Address bits [1:0] are ignored.
- R8: A read request returns the entry on `hostRdata` one clock later, with `hostRdValid` high for exactly that clock.
- R9: After reset every entry holds 0x000100FF, so every output slot carries 0xFF. `outValid` and `hostRdValid` are low while reset is held.
- R10: A host write replaces an entry as a whole word. The new value drives its output slot from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Marks slot 0 and swaps the data memory banks |
| inByte | input | 8 | Input byte of the current slot |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | log2(NUM_CH)+2 | Host byte address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data |
| hostRdValid | output | 1 | Read data valid |
| outValid | output | 1 | Output byte valid |
| outSlot | output | log2(NUM_CH) | Output slot number |
| outByte | output | 8 | Switched or substituted byte |

## Verification
Every input slot carries a byte that depends on both the frame number and the slot number. A wrong source channel therefore gives a wrong value, and so does a wrong bank, since the wrong bank yields the current frame instead of the previous one.

The connection table is built to separate the behaviours:

- plain routes, including fan-out of one input to two outputs;
- routes with spare high channel bits, which must act as their low-bit alias;
- routes with the spare bit 17 set, paired with an identical route that has it clear;
- constant entries, one of which keeps data-like bits below bit 16;
- an all-ones word, which tests the unused high bits.

Further directed tests cover the idle state after reset, the read latency, address bits [1:0] that are ignored, and an entry that is rewritten while traffic is running.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int ENTRY_W = 18;
  localparam int SUB_BIT = 16;
  localparam int SW_BIT  = 17;

  // Strobes from control to datapath for the current clock
  typedef struct packed {
    logic [15:0] slot;     // slot handled this clock
    logic        bank;     // bank being filled this clock
    logic        hostWe;
    logic        hostRe;
    logic [15:0] hostIdx;  // entry index from host byte address
  } tsiStrobes_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int NUM_CH = 256,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  output tsiStrobes_t       strb
);
  logic [CH_W-1:0] slotCnt;
  logic [CH_W-1:0] curSlot;
  logic            fillBank;
  logic            curBank;

  always_comb begin
    curSlot = frameSync ? '0 : slotCnt;
    curBank = frameSync ? ~fillBank : fillBank;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt  <= '0;
      fillBank <= 1'b0;
    end else begin
      slotCnt  <= (curSlot == CH_W'(NUM_CH - 1)) ? '0 : curSlot + 1'b1;
      fillBank <= curBank;
    end
  end

  always_comb begin
    strb.slot    = 16'(curSlot);
    strb.bank    = curBank;
    strb.hostWe  = hostWr;
    strb.hostRe  = hostRd;
    strb.hostIdx = 16'(hostAddr[ADDR_W-1:2]);
  end
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int NUM_CH = 256,
  parameter logic [7:0] IDLE_BYTE = 8'hFF,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  tsiStrobes_t     strb,
  input  logic [7:0]      inByte,
  input  logic [31:0]     hostWdata,
  output logic [31:0]     hostRdata,
  output logic            hostRdValid,
  output logic            outValid,
  output logic [CH_W-1:0] outSlot,
  output logic [7:0]      outByte
);
  localparam logic [ENTRY_W-1:0] RESET_ENTRY = {2'b01, 8'h00, IDLE_BYTE};

  logic [ENTRY_W-1:0] cnctMem [NUM_CH];
  logic [7:0]         dataMem [2][NUM_CH];

  logic [CH_W-1:0] slotIdx;
  logic [CH_W-1:0] hostIdx;

  assign slotIdx = strb.slot[CH_W-1:0];
  assign hostIdx = strb.hostIdx[CH_W-1:0];

  // Connection memory: host write port, whole-entry update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) cnctMem[i] <= RESET_ENTRY;
    end else if (strb.hostWe) begin
      cnctMem[hostIdx] <= hostWdata[ENTRY_W-1:0];
    end
  end

  // Data memory: fill the current bank at the current slot
  always_ff @(posedge clk) begin
    dataMem[strb.bank][slotIdx] <= inByte;
  end

  // Stage 1: connection lookup, remember the replay bank
  logic               s1Valid;
  logic [CH_W-1:0]    s1Slot;
  logic [ENTRY_W-1:0] s1Entry;
  logic               s1Bank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Slot  <= '0;
      s1Entry <= RESET_ENTRY;
      s1Bank  <= 1'b0;
    end else begin
      s1Valid <= 1'b1;
      s1Slot  <= slotIdx;
      s1Entry <= cnctMem[slotIdx];
      s1Bank  <= ~strb.bank;
    end
  end

  // Stage 2: data fetch or pattern substitution
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSlot  <= '0;
      outByte  <= IDLE_BYTE;
    end else begin
      outValid <= s1Valid;
      outSlot  <= s1Slot;
      outByte  <= s1Entry[SUB_BIT] ? s1Entry[7:0]
                                   : dataMem[s1Bank][s1Entry[CH_W-1:0]];
    end
  end

  // Host read port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdValid <= 1'b0;
      hostRdata   <= '0;
    end else begin
      hostRdValid <= strb.hostRe;
      if (strb.hostRe) hostRdata <= {{(32-ENTRY_W){1'b0}}, cnctMem[hostIdx]};
    end
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NUM_CH = 256,
  parameter logic [7:0] IDLE_BYTE = 8'hFF,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic [7:0]        inByte,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              hostRdValid,
  output logic              outValid,
  output logic [CH_W-1:0]   outSlot,
  output logic [7:0]        outByte
);
  tsiStrobes_t strb;

  tsi_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr), .strb(strb)
  );

  tsi_datapath #(.NUM_CH(NUM_CH), .IDLE_BYTE(IDLE_BYTE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inByte(inByte),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostRdValid(hostRdValid),
    .outValid(outValid), .outSlot(outSlot), .outByte(outByte)
  );
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int NUM_CH = 256,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic            clk,
  input logic            rstN,
  input logic            frameSync,
  input logic            hostRd,
  input logic [31:0]     hostRdata,
  input logic            hostRdValid,
  input logic            outValid,
  input logic [CH_W-1:0] outSlot
);
  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid) && outSlot != '0) |-> outSlot == CH_W'($past(outSlot) + 1'b1));

  // R2
  sync_to_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> ##1 (outValid && outSlot == '0));

  // R6
  high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRdValid |-> hostRdata[31:18] == 14'b0);

  // R8
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRd |=> hostRdValid);

  // R8
  rd_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostRd |=> !hostRdValid);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && !hostRdValid));
endmodule

bind tsi_switch tsi_switch_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .frameSync(frameSync), .hostRd(hostRd),
  .hostRdata(hostRdata), .hostRdValid(hostRdValid),
  .outValid(outValid), .outSlot(outSlot)
);

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  localparam int NCH = 16;
  localparam int CW = 4;
  localparam int AW = CW + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSync = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic hostWr = 1'b0;
  logic hostRd = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic hostRdValid;
  logic outValid;
  logic [CW-1:0] outSlot;
  logic [7:0] outByte;

  always #5 clk = ~clk;

  tsi_switch #(.NUM_CH(NCH)) i_tsi_switch (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .inByte(inByte),
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostRdValid(hostRdValid),
    .outValid(outValid), .outSlot(outSlot), .outByte(outByte)
  );

  int vecs = 0;
  int errs = 0;
  bit running = 1'b0;
  int drvSlot = 0, drvFrame = 0;
  int dfr1 = -1, dfr2 = -1, dsl1 = 0, dsl2 = 0;
  int lastWriteFrame = -1;
  logic [17:0] model [NCH];

  // {output slot, entry word}
  localparam logic [35:0] VEC [12] = '{
    {4'd5,  32'h0000_0001},   // R2 route 1 -> 5
    {4'd6,  32'h0001_0001},   // R3 constant 0x01
    {4'd0,  32'h0000_000F},   // R2 last input to first output
    {4'd15, 32'h0000_0000},   // R2 first input to last output
    {4'd7,  32'hFFFF_FFFF},   // R6 high bits dropped, constant 0xFF
    {4'd8,  32'h0002_0003},   // R5 spare bit with route 3
    {4'd9,  32'h0000_0003},   // R5 same route without spare bit
    {4'd10, 32'h0000_0012},   // R4 alias of input 2
    {4'd11, 32'h0000_FFF4},   // R4 alias of input 4
    {4'd12, 32'h0003_005A},   // R3 constant with spare bit
    {4'd1,  32'h0000_0001},   // R2 fan-out of input 1
    {4'd2,  32'h0001_0000}    // R3 constant 0x00
  };

  function automatic logic [7:0] pat(int f, int i);
    return 8'(f * 29 + i * 7 + 1);
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // Sample outputs, then drive the next slot, both on the falling edge
  always @(negedge clk) begin
    if (running) begin
      if (outValid && dfr2 >= 0) begin
        check(32'(outSlot), 32'(dsl2), "R1 slot order");
        if (dfr2 > lastWriteFrame) begin
          logic [17:0] e;
          e = model[outSlot];
          if (e[16])
            check(32'(outByte), 32'(e[7:0]), lastWriteFrame < 0 ? "R9 idle" : "R3 constant");
          else if (dfr2 >= 1)
            check(32'(outByte), 32'(pat(dfr2 - 1, int'(e[3:0]))), "R2/R4/R5/R10 route");
        end
      end
      dfr2 = dfr1; dsl2 = dsl1;
      dfr1 = drvFrame; dsl1 = drvSlot;
      frameSync = (drvSlot == 0);
      inByte = pat(drvFrame, drvSlot);
      drvSlot++;
      if (drvSlot == NCH) begin
        drvSlot = 0;
        drvFrame++;
      end
    end
  end

  task automatic hostWrite(input int idx, input logic [31:0] word);
    @(negedge clk);
    hostWr = 1'b1;
    hostAddr = AW'(idx * 4);
    hostWdata = word;
    model[idx] = word[17:0];
    lastWriteFrame = drvFrame + 1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [AW-1:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    hostRd = 1'b1;
    hostAddr = addr;
    @(negedge clk);
    hostRd = 1'b0;
    check(32'(hostRdValid), 32'd1, "R8 valid after one clock");
    check(hostRdata, exp, tag);
    @(negedge clk);
    check(32'(hostRdValid), 32'd0, "R8 valid one clock only");
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) model[i] = 18'h100FF;
    waitCycles(3);
    // R9: quiet outputs during reset
    check(32'(outValid), 32'd0, "R9 outValid in reset");
    check(32'(hostRdValid), 32'd0, "R9 hostRdValid in reset");
    rstN = 1'b1;
    running = 1'b1;
    waitCycles(2 * NCH);
    hostRead(AW'(3 * 4), 32'h0001_00FF, "R9 reset entry");

    for (int v = 0; v < 12; v++) hostWrite(int'(VEC[v][35:32]), VEC[v][31:0]);
    waitCycles(3 * NCH);

    // R5/R6: readback of each entry
    for (int v = 0; v < 12; v++)
      hostRead(AW'(int'(VEC[v][35:32]) * 4), VEC[v][31:0] & 32'h0003_FFFF, "R5/R6 readback");

    // R7: low address bits ignored
    hostRead(AW'(5 * 4 + 3), 32'h0000_0001, "R7 byte offset ignored");

    // R10: rewrite a live entry as a whole word
    hostWrite(5, 32'h0001_00A5);
    waitCycles(3 * NCH);
    hostRead(AW'(5 * 4), 32'h0001_00A5, "R10 new entry");
    hostWrite(5, 32'h0000_000E);
    waitCycles(3 * NCH);

    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule